// File: doc/BRIEF.md
# Sequential Block Lookahead Prefetcher

This block sits beside a cache and watches its stream of demand references. Each reference comes with a block address and a hit or miss flag. When the selected trigger policy fires, the block emits prefetch requests for the blocks that come after the referenced one. It issues one block address per cycle on a valid/ready channel toward the next memory level. Requests never go past the end of the 4 KiB page that holds the reference.

Three trigger policies are available. The first fires on every reference. The second fires on misses only. The third fires on the first use of a block, meaning a miss or the first hit to a line that a prefetch brought in. For the third policy, the block keeps a one-bit "prefetched, still unused" mark for every cache line. A fill report from the cache sets or clears that mark. A small configuration port writes the policy and the lookahead degree. The degree sets how many consecutive blocks one trigger requests.

Top module: `seq_lookahead_pf`

## Requirements
- R1: After reset `pf_valid` is 0, the policy is on-miss (code 1) and the degree is 1.
- R2: Under policy code 0 (always), every reference triggers a burst, whether `ref_hit` is 1 or 0.
- R3: Under policy code 1 (on-miss), a reference with `ref_hit`=1 triggers nothing, and a reference with `ref_hit`=0 triggers a burst.
- R4: Under policy code 2 (tagged), a reference triggers a burst when it misses or when the mark of its line is set. A fill with `fill_is_pf`=1 sets the mark of line `addr[11:6]`, and a fill with `fill_is_pf`=0 clears it. A demand hit clears the mark of its line, so a second hit to that line triggers nothing.
- R5: With degree P, a burst requests the blocks at aligned reference address + k×64 for k = 1..P, in ascending order. The first request is valid in the cycle after the reference is sampled.
- R6: A burst is cut at the 4 KiB page end. Candidates past address bit 12 rollover are dropped, so a reference to the last block of a page issues nothing.
- R7: The block issues at most one request per cycle. While `pf_ready` is 0, `pf_valid` and `pf_addr` hold steady.
- R8: A reference that arrives while a burst is still outstanding triggers nothing.
- R9: Writing degree 0 disables issue. Degree writes above 8 are clipped to 8. Policy code 3 disables issue.
- R10: The byte-offset bits `ref_addr[5:0]` do not affect the requested addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for policy and degree |
| cfg_mode | input | 2 | Policy: 0 always, 1 on-miss, 2 tagged, 3 off |
| cfg_degree | input | 4 | Requested lookahead degree |
| ref_valid | input | 1 | Demand reference strobe |
| ref_addr | input | 32 | Demand byte address |
| ref_hit | input | 1 | 1 = hit, 0 = miss |
| fill_valid | input | 1 | Line fill report strobe |
| fill_addr | input | 32 | Byte address of the filled line |
| fill_is_pf | input | 1 | 1 = fill caused by a prefetch |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Next level accepts request |
| pf_addr | output | 32 | Block-aligned prefetch address |

## Verification
A reference is sampled on one clock edge, and its first request is visible right after that edge. Each later block follows one edge after the previous one is accepted. The bench drives stimulus at falling edges and samples `pf_valid`/`pf_addr` at each following falling edge. While `pf_ready` is high it expects the k-th address on the k-th sample. A configuration or fill write takes effect on the edge that samples it, so the bench applies it at least one falling edge before the reference it influences. Back-pressure checks hold `pf_ready` low across several samples and expect the same address each time.

// File: rtl/seq_lookahead_pf.sv
module seq_lookahead_pf #(
  parameter int ADDR_W     = 32,
  parameter int BLK_BYTES  = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int NUM_LINES  = 64,
  parameter int MAX_DEG    = 8,
  localparam int DEG_W     = $clog2(MAX_DEG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [DEG_W-1:0]  cfg_degree,
  input  logic              ref_valid,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic              ref_hit,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_is_pf,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int BO    = $clog2(BLK_BYTES);
  localparam int PG    = $clog2(PAGE_BYTES);
  localparam int PB_W  = PG - BO;
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int CW    = ((PB_W > DEG_W) ? PB_W : DEG_W) + 1;
  localparam logic [ADDR_W-1:0] BLK = ADDR_W'(BLK_BYTES);
  localparam logic [1:0] M_ALWAYS = 2'd0, M_MISS = 2'd1, M_TAG = 2'd2;

  logic [1:0]           mode_q;
  logic [DEG_W-1:0]     deg_q;
  logic [NUM_LINES-1:0] tag_q;
  logic [ADDR_W-1:0]    next_q;
  logic [CW-1:0]        remain_q;

  logic [IDX_W-1:0] ref_idx, fill_idx;
  logic [PB_W-1:0]  left;
  logic [CW-1:0]    cnt;
  logic             want, start, fire;

  assign ref_idx  = ref_addr[BO +: IDX_W];
  assign fill_idx = fill_addr[BO +: IDX_W];
  assign left     = {PB_W{1'b1}} - ref_addr[BO +: PB_W];
  assign cnt      = (CW'(deg_q) < CW'(left)) ? CW'(deg_q) : CW'(left);
  assign pf_valid = remain_q != '0;
  assign pf_addr  = next_q;
  assign fire     = pf_valid && pf_ready;

  always_comb begin
    case (mode_q)
      M_ALWAYS: want = 1'b1;
      M_MISS:   want = !ref_hit;
      M_TAG:    want = !ref_hit || tag_q[ref_idx];
      default:  want = 1'b0;
    endcase
  end

  assign start = ref_valid && !pf_valid && want && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_MISS;
      deg_q  <= DEG_W'(1);
    end else if (cfg_we) begin
      mode_q <= cfg_mode;
      deg_q  <= (cfg_degree > DEG_W'(MAX_DEG)) ? DEG_W'(MAX_DEG) : cfg_degree;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else begin
      if (ref_valid && ref_hit) tag_q[ref_idx] <= 1'b0;
      if (fill_valid) tag_q[fill_idx] <= fill_is_pf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_q   <= '0;
      remain_q <= '0;
    end else if (start) begin
      next_q   <= {ref_addr[ADDR_W-1:BO], {BO{1'b0}}} + BLK;
      remain_q <= cnt;
    end else if (fire) begin
      next_q   <= next_q + BLK;
      remain_q <= remain_q - 1'b1;
    end
  end

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

  // R5
  ascending_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready |=> !pf_valid || (pf_addr == $past(pf_addr) + BLK));

  // R6
  same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready |=> !pf_valid || (pf_addr[ADDR_W-1:PG] == $past(pf_addr[ADDR_W-1:PG])));

  // R6
  no_page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr[PG-1:BO] != '0) && (pf_addr[BO-1:0] == '0));

  // R9
  zero_degree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_valid && (deg_q == '0) && !cfg_we |=> !pf_valid);

  // R9
  degree_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deg_q <= DEG_W'(MAX_DEG));
endmodule

// File: tb/seq_lookahead_pf_tb.sv
`timescale 1ns/1ps
module seq_lookahead_pf_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_mode = 0;
  logic [3:0]  cfg_degree = 0;
  logic        ref_valid = 0;
  logic [31:0] ref_addr = 0;
  logic        ref_hit = 0;
  logic        fill_valid = 0;
  logic [31:0] fill_addr = 0;
  logic        fill_is_pf = 0;
  logic        pf_valid;
  logic        pf_ready = 1;
  logic [31:0] pf_addr;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seq_lookahead_pf u_dut (.*);

  // {mode, degree, ref addr, hit, expected count, expected first address}
  localparam int NV = 11;
  localparam logic [74:0] VEC [NV] = '{
    {2'd0, 4'd1, 32'h1000_0040, 1'b1, 4'd1, 32'h1000_0080},  // R2 hit
    {2'd0, 4'd2, 32'h1000_0200, 1'b0, 4'd2, 32'h1000_0240},  // R2 miss
    {2'd0, 4'd4, 32'h2000_0F00, 1'b1, 4'd3, 32'h2000_0F40},  // R6 clip
    {2'd1, 4'd2, 32'h3000_0100, 1'b1, 4'd0, 32'h0},          // R3 hit
    {2'd1, 4'd2, 32'h3000_0100, 1'b0, 4'd2, 32'h3000_0140},  // R3 miss
    {2'd2, 4'd3, 32'h4000_0200, 1'b0, 4'd3, 32'h4000_0240},  // R4 miss
    {2'd2, 4'd3, 32'h4000_0240, 1'b1, 4'd0, 32'h0},          // R4 untagged hit
    {2'd0, 4'd8, 32'h5000_0FC0, 1'b0, 4'd0, 32'h0},          // R6 last block
    {2'd0, 4'd8, 32'h5000_0000, 1'b0, 4'd8, 32'h5000_0040},  // R5 degree 8
    {2'd3, 4'd4, 32'h5000_0000, 1'b0, 4'd0, 32'h0},          // R9 off
    {2'd0, 4'd2, 32'h6000_0123, 1'b1, 4'd2, 32'h6000_0140}   // R10 offset
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] m, input logic [3:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_mode = m; cfg_degree = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic fill(input logic [31:0] a, input bit p);
    @(negedge clk);
    fill_valid = 1; fill_addr = a; fill_is_pf = p;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic send_ref(input logic [31:0] a, input bit h);
    @(negedge clk);
    ref_valid = 1; ref_addr = a; ref_hit = h;
    @(negedge clk);
    ref_valid = 0;
  endtask

  // called at the negedge right after a reference was sampled
  task automatic collect(input int n, input logic [31:0] first, input string req);
    int got = 0;
    for (int c = 0; c < 14; c++) begin
      if (pf_valid) begin
        if (got < n)
          check(pf_addr == first + 32'(64 * got), req, pf_addr, first + 32'(64 * got));
        if (pf_ready) got++;
      end
      @(negedge clk);
    end
    check(got == n, req, 32'(got), 32'(n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(pf_valid == 0, "R1 valid", 32'(pf_valid), 0);
    // R1: default on-miss, degree 1
    send_ref(32'h0A00_0100, 1'b1);
    collect(0, 0, "R1 hit default");
    send_ref(32'h0A00_0100, 1'b0);
    collect(1, 32'h0A00_0140, "R1 miss default");

    for (int i = 0; i < NV; i++) begin
      cfg(VEC[i][74:73], VEC[i][72:69]);
      send_ref(VEC[i][68:37], VEC[i][36]);
      collect(int'(VEC[i][35:32]), VEC[i][31:0], $sformatf("R5 vec%0d", i));
    end

    // R4 tagged line set by prefetch fill, cleared by first hit
    cfg(2'd2, 4'd1);
    fill(32'h7000_0080, 1'b1);
    send_ref(32'h7000_0080, 1'b1);
    collect(1, 32'h7000_00C0, "R4 first hit");
    send_ref(32'h7000_0080, 1'b1);
    collect(0, 0, "R4 second hit");
    fill(32'h7000_0300, 1'b0);
    send_ref(32'h7000_0300, 1'b1);
    collect(0, 0, "R4 demand fill");

    // R7 back-pressure, R8 trigger while busy
    cfg(2'd0, 4'd3);
    pf_ready = 0;
    send_ref(32'h8000_0000, 1'b0);
    check(pf_valid && pf_addr == 32'h8000_0040, "R7 first", pf_addr, 32'h8000_0040);
    send_ref(32'h8000_0400, 1'b0);
    check(pf_valid && pf_addr == 32'h8000_0040, "R7 hold", pf_addr, 32'h8000_0040);
    @(negedge clk);
    check(pf_valid && pf_addr == 32'h8000_0040, "R7 hold2", pf_addr, 32'h8000_0040);
    pf_ready = 1;
    collect(3, 32'h8000_0040, "R8 busy ignore");

    // R9 degree clip and zero
    cfg(2'd0, 4'd12);
    send_ref(32'h9000_0000, 1'b1);
    collect(8, 32'h9000_0040, "R9 clip");
    cfg(2'd0, 4'd0);
    send_ref(32'h9000_0000, 1'b0);
    collect(0, 0, "R9 zero");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule